// File: doc/BRIEF.md
# Double-Rate Two-Word Burst Static Memory

This block models a static memory with separate write-data and read-data buses. It moves two words per transaction on each bus. One fabric clock drives it. Each clock cycle carries two data slots: a first slot, which stands for the rising half of the cycle, and a second slot, which stands for the falling half. A command is a load strobe, a read select and a pair address, and it is sampled once per clock edge. The pair address `A` selects two adjacent words. Word `2A` always travels in the first beat of the burst and word `2A+1` in the second.

Write data follows its command by one edge. Each of the two beats has its own active-low byte enables, and the array is updated at that edge. Read data leaves on a pipeline with one of two latencies, chosen by a mode input. In the half-step mode the burst straddles a cycle boundary. In the whole-step mode both words come out together in one cycle. A read issued while the previous write's data is arriving returns the freshly written bytes, merged with the stored bytes they did not replace. Each output slot has a valid flag. While the flag is low the slot is idle, which stands in for a high-impedance bus.

After reset the block stays closed until it has seen a short run of idle cycles. Every command before that point is discarded.

Top module: `ddr2b_sram`

## Requirements
- R1: A command is taken only at an edge where `cmd_load_n` is low. An edge with `cmd_load_n` high is idle: it is accepted as neither a read nor a write, and `cmd_addr` and `cmd_rd` have no effect.
- R2: With `cmd_load_n` low, `cmd_rd` high selects a read and `cmd_rd` low selects a write.
- R3: Pair address `A` maps to words `2A` and `2A+1`. The even word is always the first beat and the odd word the second, in both directions.
- R4: For a write accepted at edge E, `wd_first` and `wd_second`, sampled at edge E+1, are stored into words `2A` and `2A+1` at that edge. No storage update happens without an accepted write one edge earlier.
- R5: With `lat_mode_half` = 1, a read accepted at edge E shows word `2A` in the second slot after edge E+1 and word `2A+1` in the first slot after edge E+2. If no read is accepted at E+1, the second slot after E+2 is idle, so the bus is released 2.5 cycles after the read.
- R6: With `lat_mode_half` = 0, a read accepted at edge E shows word `2A` in the first slot and word `2A+1` in the second slot, both after edge E+1.
- R7: Byte enables are active low and apply per beat: `wbe_first_n` with `wd_first`, `wbe_second_n` with `wd_second`. Enable bit 0 gates data bits 0 to 8 and bit 1 gates bits 9 to 17. Bytes not enabled keep their old value, and a beat with all enables high writes nothing.
- R8: A read accepted at the edge where a write's data arrives, and aimed at the same pair, returns the new bytes merged with the stored bytes the enables left untouched.
- R9: After reset, commands are accepted only once four consecutive idle edges have been seen. A command edge during this gate is discarded and restarts the count, and no read output results from it.
- R10: While a slot's valid flag is low its data is all zeros. Both flags and both data slots are low during and right after reset.
- R11: Reset does not clear the storage array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lat_mode_half | input | 1 | 1: read latency of one and a half cycles; 0: one cycle |
| cmd_load_n | input | 1 | Active-low load strobe |
| cmd_rd | input | 1 | Read select: 1 read, 0 write |
| cmd_addr | input | AW | Pair address |
| wd_first | input | 18 | Write data for the first beat (even word) |
| wd_second | input | 18 | Write data for the second beat (odd word) |
| wbe_first_n | input | 2 | Active-low byte enables for the first beat |
| wbe_second_n | input | 2 | Active-low byte enables for the second beat |
| rd_first | output | 18 | Read data in the first slot of the cycle |
| rd_second | output | 18 | Read data in the second slot of the cycle |
| rd_first_vld | output | 1 | First slot carries read data |
| rd_second_vld | output | 1 | Second slot carries read data |

## Verification
The properties assume that `lat_mode_half` changes only while no read is in flight. The slot-pairing and tail checks compare one edge with the next, and a mode change in the middle of a burst would break that comparison. The bench changes the mode only after the pipeline has drained, behind idle cycles. The properties also take the command inputs to be settled before each edge. The bench therefore drives inputs on the falling edge and samples outputs shortly after the rising edge.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;

    localparam int DEF_AW        = 4;
    localparam int DEF_BYTE_W    = 9;
    localparam int DEF_N_BYTES   = 2;
    localparam int DEF_INIT_NOPS = 4;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        logic first;
        logic second;
    } slot_en_t;

    function automatic op_e decode_op(input logic load_n, input logic rd);
        if (load_n) return OP_IDLE;
        return rd ? OP_READ : OP_WRITE;
    endfunction

endpackage

// File: rtl/ddr2b_init_gate.sv
module ddr2b_init_gate #(
    parameter int INIT_NOPS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load_n,
    output logic ready
);
    localparam int CW = $clog2(INIT_NOPS + 1);

    logic [CW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
            ready    <= 1'b0;
        end else if (!ready) begin
            if (!load_n) begin
                idle_cnt <= '0;
            end else if (idle_cnt == CW'(INIT_NOPS - 1)) begin
                ready <= 1'b1;
            end else begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ddr2b_byte_merge.sv
module ddr2b_byte_merge #(
    parameter int BYTE_W  = 9,
    parameter int N_BYTES = 2
) (
    input  logic [BYTE_W*N_BYTES-1:0] old_w,
    input  logic [BYTE_W*N_BYTES-1:0] new_w,
    input  logic [N_BYTES-1:0]        en_n,
    output logic [BYTE_W*N_BYTES-1:0] out_w
);
    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
        assign out_w[b*BYTE_W +: BYTE_W] = en_n[b] ? old_w[b*BYTE_W +: BYTE_W]
                                                   : new_w[b*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/ddr2b_store.sv
module ddr2b_store #(
    parameter int AW      = 4,
    parameter int BYTE_W  = 9,
    parameter int N_BYTES = 2
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [BYTE_W*N_BYTES-1:0] wd0,
    input  logic [BYTE_W*N_BYTES-1:0] wd1,
    input  logic [N_BYTES-1:0]        wbe0_n,
    input  logic [N_BYTES-1:0]        wbe1_n,
    input  logic [AW-1:0]             raddr,
    output logic [BYTE_W*N_BYTES-1:0] rq0,
    output logic [BYTE_W*N_BYTES-1:0] rq1
);
    localparam int DW    = BYTE_W * N_BYTES;
    localparam int WA    = AW + 1;
    localparam int DEPTH = 1 << WA;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] old0, old1, mg0, mg1;
    logic          hit;

    assign old0 = mem[{raddr, 1'b0}];
    assign old1 = mem[{raddr, 1'b1}];
    assign hit  = we && (waddr == raddr);

    ddr2b_byte_merge #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_mg0 (
        .old_w(old0), .new_w(wd0), .en_n(wbe0_n), .out_w(mg0)
    );
    ddr2b_byte_merge #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_mg1 (
        .old_w(old1), .new_w(wd1), .en_n(wbe1_n), .out_w(mg1)
    );

    always_ff @(posedge clk) begin
        for (int b = 0; b < N_BYTES; b++) begin
            if (we && !wbe0_n[b]) mem[{waddr, 1'b0}][b*BYTE_W +: BYTE_W] <= wd0[b*BYTE_W +: BYTE_W];
            if (we && !wbe1_n[b]) mem[{waddr, 1'b1}][b*BYTE_W +: BYTE_W] <= wd1[b*BYTE_W +: BYTE_W];
        end
        rq0 <= hit ? mg0 : old0;
        rq1 <= hit ? mg1 : old1;
    end
endmodule

// File: rtl/ddr2b_rd_pipe.sv
module ddr2b_rd_pipe
    import ddr2b_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          half_mode,
    input  logic          s1_v,
    input  logic [DW-1:0] w0,
    input  logic [DW-1:0] w1,
    output logic [DW-1:0] q_first,
    output logic [DW-1:0] q_second,
    output slot_en_t      q_en
);
    logic          hold_v;
    logic [DW-1:0] hold_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_first  <= '0;
            q_second <= '0;
            q_en     <= '0;
            hold_v   <= 1'b0;
            hold_w   <= '0;
        end else if (half_mode) begin
            q_en.second <= s1_v;
            q_second    <= s1_v ? w0 : '0;
            q_en.first  <= hold_v;
            q_first     <= hold_v ? hold_w : '0;
            hold_v      <= s1_v;
            hold_w      <= w1;
        end else begin
            q_en.first  <= s1_v;
            q_en.second <= s1_v;
            q_first     <= s1_v ? w0 : '0;
            q_second    <= s1_v ? w1 : '0;
            hold_v      <= 1'b0;
            hold_w      <= '0;
        end
    end
endmodule

// File: rtl/ddr2b_sram.sv
module ddr2b_sram
    import ddr2b_pkg::*;
#(
    parameter int AW        = DEF_AW,
    parameter int BYTE_W    = DEF_BYTE_W,
    parameter int N_BYTES   = DEF_N_BYTES,
    parameter int INIT_NOPS = DEF_INIT_NOPS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      lat_mode_half,
    input  logic                      cmd_load_n,
    input  logic                      cmd_rd,
    input  logic [AW-1:0]             cmd_addr,
    input  logic [BYTE_W*N_BYTES-1:0] wd_first,
    input  logic [BYTE_W*N_BYTES-1:0] wd_second,
    input  logic [N_BYTES-1:0]        wbe_first_n,
    input  logic [N_BYTES-1:0]        wbe_second_n,
    output logic [BYTE_W*N_BYTES-1:0] rd_first,
    output logic [BYTE_W*N_BYTES-1:0] rd_second,
    output logic                      rd_first_vld,
    output logic                      rd_second_vld
);
    localparam int DW = BYTE_W * N_BYTES;

    op_e           op;
    logic          ready;
    logic          rd_acc, wr_acc;
    logic          wr_pend_v;
    logic [AW-1:0] wr_pend_addr;
    logic          s1_v;
    logic [DW-1:0] rq0, rq1;
    slot_en_t      q_en;

    assign op     = decode_op(cmd_load_n, cmd_rd);
    assign rd_acc = ready && (op == OP_READ);
    assign wr_acc = ready && (op == OP_WRITE);

    ddr2b_init_gate #(.INIT_NOPS(INIT_NOPS)) u_gate (
        .clk(clk), .rst(rst), .load_n(cmd_load_n), .ready(ready)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pend_v    <= 1'b0;
            wr_pend_addr <= '0;
            s1_v         <= 1'b0;
        end else begin
            wr_pend_v    <= wr_acc;
            wr_pend_addr <= cmd_addr;
            s1_v         <= rd_acc;
        end
    end

    ddr2b_store #(.AW(AW), .BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_store (
        .clk(clk), .we(wr_pend_v), .waddr(wr_pend_addr),
        .wd0(wd_first), .wd1(wd_second),
        .wbe0_n(wbe_first_n), .wbe1_n(wbe_second_n),
        .raddr(cmd_addr), .rq0(rq0), .rq1(rq1)
    );

    ddr2b_rd_pipe #(.DW(DW)) u_rpipe (
        .clk(clk), .rst(rst), .half_mode(lat_mode_half), .s1_v(s1_v),
        .w0(rq0), .w1(rq1),
        .q_first(rd_first), .q_second(rd_second), .q_en(q_en)
    );

    assign rd_first_vld  = q_en.first;
    assign rd_second_vld = q_en.second;
endmodule

// File: rtl/ddr2b_sram_chk.sv
module ddr2b_sram_chk #(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          lat_mode_half,
    input logic          cmd_load_n,
    input logic          cmd_rd,
    input logic          ready,
    input logic          wr_acc,
    input logic          mem_we,
    input logic [DW-1:0] rd_first,
    input logic [DW-1:0] rd_second,
    input logic          rd_first_vld,
    input logic          rd_second_vld
);
    // R1 / R2: second-slot data only follows a read command two edges back
    p_read_origin_r1: assert property (@(posedge clk) disable iff (rst)
        rd_second_vld |-> $past(!cmd_load_n && cmd_rd, 2));

    // R4: storage update only after an accepted write
    p_write_commit_r4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(wr_acc));

    // R5: first-slot word in half mode always trails a second-slot word
    p_half_tail_r5: assert property (@(posedge clk) disable iff (rst)
        (lat_mode_half && $past(lat_mode_half) && $past(lat_mode_half, 2) && rd_first_vld)
        |-> $past(rd_second_vld));

    // R6: whole-step mode delivers both slots together
    p_full_pair_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(lat_mode_half) |-> (rd_first_vld == rd_second_vld));

    // R9: gate opens only after an idle edge
    p_gate_open_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(cmd_load_n));

    // R10: idle slots carry zeros
    p_zero_first_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_first_vld |-> (rd_first == '0));
    p_zero_second_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_second_vld |-> (rd_second == '0));
endmodule

bind ddr2b_sram ddr2b_sram_chk #(.DW(BYTE_W*N_BYTES)) u_chk (
    .clk(clk), .rst(rst), .lat_mode_half(lat_mode_half),
    .cmd_load_n(cmd_load_n), .cmd_rd(cmd_rd),
    .ready(ready), .wr_acc(wr_acc), .mem_we(wr_pend_v),
    .rd_first(rd_first), .rd_second(rd_second),
    .rd_first_vld(rd_first_vld), .rd_second_vld(rd_second_vld)
);

// File: tb/ddr2b_sram_tb.sv
module ddr2b_sram_tb;
    localparam int AW = 4;
    localparam int DW = 18;
    localparam int EW = 1 + AW + DW + DW + 2 + 2;
    localparam int NT = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lat_mode_half = 1'b1;
    logic          cmd_load_n = 1'b1;
    logic          cmd_rd = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] wd_first = '0, wd_second = '0;
    logic [1:0]    wbe_first_n = 2'b11, wbe_second_n = 2'b11;
    logic [DW-1:0] rd_first, rd_second;
    logic          rd_first_vld, rd_second_vld;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;
    logic [DW-1:0] ref_mem [2**(AW+1)];

    always #4 clk = ~clk;

    ddr2b_sram u_dut (
        .clk(clk), .rst(rst), .lat_mode_half(lat_mode_half),
        .cmd_load_n(cmd_load_n), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
        .wd_first(wd_first), .wd_second(wd_second),
        .wbe_first_n(wbe_first_n), .wbe_second_n(wbe_second_n),
        .rd_first(rd_first), .rd_second(rd_second),
        .rd_first_vld(rd_first_vld), .rd_second_vld(rd_second_vld)
    );

    // {is_write, pair, first word, second word, first enables_n, second enables_n}
    localparam logic [EW-1:0] TBL [NT] = '{
        {1'b1, 4'd2,  18'h12345, 18'h0ABCD, 2'b00, 2'b00},
        {1'b1, 4'd5,  18'h3FFFF, 18'h00001, 2'b00, 2'b00},
        {1'b0, 4'd2,  18'h00000, 18'h00000, 2'b11, 2'b11},
        {1'b1, 4'd2,  18'h00000, 18'h3FFFF, 2'b10, 2'b01},
        {1'b0, 4'd2,  18'h00000, 18'h00000, 2'b11, 2'b11},
        {1'b1, 4'd5,  18'h2AAAA, 18'h15555, 2'b11, 2'b11},
        {1'b0, 4'd5,  18'h00000, 18'h00000, 2'b11, 2'b11},
        {1'b1, 4'd9,  18'h0F0F0, 18'h30303, 2'b00, 2'b00},
        {1'b1, 4'd7,  18'h11111, 18'h22222, 2'b00, 2'b00},
        {1'b0, 4'd9,  18'h00000, 18'h00000, 2'b11, 2'b11},
        {1'b1, 4'd15, 18'h1C3C3, 18'h2E1E1, 2'b01, 2'b00},
        {1'b0, 4'd15, 18'h00000, 18'h00000, 2'b11, 2'b11}
    };

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic ld_n, input logic rd, input logic [AW-1:0] a,
                        input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                        input logic [1:0] b0, input logic [1:0] b1);
        @(negedge clk);
        cmd_load_n = ld_n; cmd_rd = rd; cmd_addr = a;
        wd_first = d0; wd_second = d1; wbe_first_n = b0; wbe_second_n = b1;
        @(posedge clk);
        #2;
    endtask

    task automatic nop();
        step(1'b1, 1'b0, '0, '0, '0, 2'b11, 2'b11);
    endtask

    task automatic ref_write(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                             input logic [1:0] b0, input logic [1:0] b1);
        for (int b = 0; b < 2; b++) begin
            if (!b0[b]) ref_mem[{a, 1'b0}][b*9 +: 9] = d0[b*9 +: 9];
            if (!b1[b]) ref_mem[{a, 1'b1}][b*9 +: 9] = d1[b*9 +: 9];
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                            input logic [1:0] b0, input logic [1:0] b1);
        step(1'b0, 1'b0, a, '0, '0, 2'b11, 2'b11);
        step(1'b1, 1'b0, '0, d0, d1, b0, b1);
        ref_write(a, d0, d1, b0, b1);
    endtask

    task automatic do_read_half(input logic [AW-1:0] a);
        step(1'b0, 1'b1, a, '0, '0, 2'b11, 2'b11);
        nop();
        chk("R5 second slot valid", {17'b0, rd_second_vld}, 18'd1);
        chk("R3/R5 even word in second slot", rd_second, ref_mem[{a, 1'b0}]);
        chk("R5 first slot idle", {17'b0, rd_first_vld}, 18'd0);
        nop();
        chk("R3/R5 odd word in first slot", rd_first, ref_mem[{a, 1'b1}]);
        chk("R5 bus released after 2.5 cycles", {17'b0, rd_second_vld}, 18'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R10: reset state
        chk("R10 reset first valid", {17'b0, rd_first_vld}, 18'd0);
        chk("R10 reset second valid", {17'b0, rd_second_vld}, 18'd0);
        chk("R10 reset first data", rd_first, '0);
        chk("R10 reset second data", rd_second, '0);
        @(negedge clk);
        rst = 1'b0;
        repeat (4) nop();

        // table walk: R2, R3, R4, R5, R7
        for (int i = 0; i < NT; i++) begin
            logic [EW-1:0] e;
            e = TBL[i];
            if (e[EW-1])
                do_write(e[EW-2 -: AW], e[39:22], e[21:4], e[3:2], e[1:0]);
            else
                do_read_half(e[EW-2 -: AW]);
        end

        // R8: read right behind a partial write to the same pair
        step(1'b0, 1'b0, 4'd2, '0, '0, 2'b11, 2'b11);
        step(1'b0, 1'b1, 4'd2, 18'h3A5A5, 18'h05A5A, 2'b01, 2'b00);
        ref_write(4'd2, 18'h3A5A5, 18'h05A5A, 2'b01, 2'b00);
        nop();
        chk("R8 forwarded even word", rd_second, ref_mem[4]);
        nop();
        chk("R8 forwarded odd word", rd_first, ref_mem[5]);

        // R5: read followed by a write releases the bus
        step(1'b0, 1'b1, 4'd5, '0, '0, 2'b11, 2'b11);
        step(1'b0, 1'b0, 4'd7, '0, '0, 2'b11, 2'b11);
        chk("R5 read-write even word", rd_second, ref_mem[10]);
        step(1'b1, 1'b0, '0, 18'h01234, 18'h04321, 2'b00, 2'b00);
        chk("R5 read-write odd word", rd_first, ref_mem[11]);
        chk("R5 read-write second slot idle", {17'b0, rd_second_vld}, 18'd0);
        ref_write(4'd7, 18'h01234, 18'h04321, 2'b00, 2'b00);

        // R5: back-to-back reads stream without gaps
        step(1'b0, 1'b1, 4'd2, '0, '0, 2'b11, 2'b11);
        step(1'b0, 1'b1, 4'd7, '0, '0, 2'b11, 2'b11);
        chk("R5 stream word 0", rd_second, ref_mem[4]);
        nop();
        chk("R5 stream word 1", rd_first, ref_mem[5]);
        chk("R5 stream word 2", rd_second, ref_mem[14]);
        nop();
        chk("R5 stream word 3", rd_first, ref_mem[15]);
        chk("R5 stream tail idle", {17'b0, rd_second_vld}, 18'd0);

        // R6: whole-step latency
        nop();
        @(negedge clk);
        lat_mode_half = 1'b0;
        nop();
        step(1'b0, 1'b1, 4'd9, '0, '0, 2'b11, 2'b11);
        nop();
        chk("R6 even word first slot", rd_first, ref_mem[18]);
        chk("R6 odd word second slot", rd_second, ref_mem[19]);
        chk("R6 both valid", {16'b0, rd_first_vld, rd_second_vld}, 18'd3);
        nop();
        chk("R6 released", {16'b0, rd_first_vld, rd_second_vld}, 18'd0);
        @(negedge clk);
        lat_mode_half = 1'b1;
        nop();

        // R1: idle edges with read select and data present do nothing
        step(1'b1, 1'b1, 4'd5, 18'h3FFFF, 18'h3FFFF, 2'b00, 2'b00);
        step(1'b1, 1'b0, 4'd5, 18'h3FFFF, 18'h3FFFF, 2'b00, 2'b00);
        chk("R1 no read output from idle edge", {16'b0, rd_first_vld, rd_second_vld}, 18'd0);
        nop();
        chk("R1 still no output", {16'b0, rd_first_vld, rd_second_vld}, 18'd0);
        do_read_half(4'd5);

        // R9 / R11: gate after reset, storage survives reset
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        nop();
        nop();
        step(1'b0, 1'b0, 4'd9, '0, '0, 2'b11, 2'b11);
        step(1'b1, 1'b0, '0, 18'h11111, 18'h22222, 2'b00, 2'b00);
        step(1'b0, 1'b1, 4'd9, '0, '0, 2'b11, 2'b11);
        nop();
        chk("R9 gated read gives no second slot", {17'b0, rd_second_vld}, 18'd0);
        nop();
        chk("R9 gated read gives no first slot", {17'b0, rd_first_vld}, 18'd0);
        nop();
        nop();
        step(1'b0, 1'b1, 4'd9, '0, '0, 2'b11, 2'b11);
        nop();
        chk("R9/R11 word 0 unchanged across reset", rd_second, ref_mem[18]);
        nop();
        chk("R9/R11 word 1 unchanged across reset", rd_first, ref_mem[19]);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule